// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block translates a virtual address into a physical address for one requester. A request carries a virtual address and an access kind (read, write or execute). The upper address bits form the virtual page number and the low bits are a page offset that passes through unchanged. The page number is first looked up in a small fully associative translation cache. On a miss the walker reads one 32-bit table entry from memory through a simple read port. It then checks that entry for validity and permission, and it loads valid entries into the cache.

Every response carries a code: success with a physical address, a page fault, or a protection fault. The walker holds the table base register. A write to that register empties the translation cache, as required when the address space changes. Only one translation is in flight at a time. The request side stays stalled until the response has been taken.

Top module: `pt_walker`

## Requirements
- R1: After reset `reqReady` is 1, `rspValid` is 0, `memReqValid` is 0 and the translation cache is empty, so the first request of any page reads memory.
- R2: The virtual page number is `reqVaddr[VA_W-1:PAGE_BITS]` (bits 31:12 by default). The entry address on `memReqAddr` is the base register value at acceptance plus four times that page number.
- R3: A successful response sets `rspFault` to 0 and `rspPaddr` to the entry's physical page number (entry bits 31:12) joined with the untouched request offset (bits 11:0).
- R4: A fetched entry with bit 0 (valid) equal to 0 gives `rspFault` = 1 (page fault) with `rspPaddr` = 0, and it is not cached: the next request to that page reads memory again.
- R5: A fetched entry with bit 0 set is placed in the cache even when the access then faults on permissions. Later requests to that page are answered without any memory read.
- R6: Permissions are checked on hits and on misses. Entry bit 1 allows read (access code 0), bit 2 allows write (code 1) and bit 3 allows execute (code 2). Access code 3 is never allowed. A violation gives `rspFault` = 2 with `rspPaddr` = 0.
- R7: A pulse on `baseWe` loads `baseWdata` into the base register and invalidates every cache entry. Later walks use the new base.
- R8: A base write that falls anywhere between the acceptance of a request and the arrival of its entry, including the very cycle in which `memRspValid` is high, stops that entry from being cached.
- R9: One translation is in flight at a time. `reqReady` is low from acceptance until the response is taken, and `rspValid` with its address and code stays steady while `rspReady` is low.
- R10: The memory read may take any number of cycles. `memReqValid` stays high with a steady `memReqAddr` until `memReqReady`, and the walker then waits for `memRspValid` however late it comes.
- R11: Cache refills replace slots in round-robin order. After a flush, with four slots, filling five distinct pages evicts the first one and keeps the other four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker accepts a request |
| reqVaddr | input | VA_W | Virtual address to translate |
| reqAccess | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rspValid | output | 1 | Response present |
| rspReady | input | 1 | Requester takes the response |
| rspPaddr | output | PA_W | Physical address, 0 on a fault |
| rspFault | output | 2 | 0 success, 1 page fault, 2 protection fault |
| baseWe | input | 1 | Write strobe for the table base register |
| baseWdata | input | PA_W | New table base value |
| memReqValid | output | 1 | Entry read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | PA_W | Byte address of the table entry |
| memRspValid | input | 1 | Entry data returned |
| memRspData | input | 32 | Returned table entry |

## Verification
Two functions can meet in one cycle: a cache refill caused by a returning entry, and the cache flush caused by a base register write. The bench's memory model can raise `baseWe` in exactly the cycle it presents `memRspValid`. The walk must still answer with the translated address, and a second request to the same page must read memory again, which shows that the flush won over the refill. A third request then hits, which shows that the refill logic works when nothing collides.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  localparam int PTE_W          = 32;
  localparam int PTE_VALID_BIT  = 0;
  localparam int PTE_PERM_LSB   = 1;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } accKind_e;

  typedef enum logic [1:0] {
    RSP_OK    = 2'd0,
    RSP_PAGE  = 2'd1,
    RSP_PROT  = 2'd2
  } rspCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;   // request taken this cycle
    logic lookup;   // cache result is evaluated this cycle
    logic absorb;   // table entry arrives this cycle
  } walkStrobe_t;

  // rwx: bit0 read, bit1 write, bit2 execute
  function automatic logic permitted(input logic [2:0] rwx, input logic [1:0] acc);
    case (acc)
      ACC_READ:  return rwx[0];
      ACC_WRITE: return rwx[1];
      ACC_EXEC:  return rwx[2];
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pt_walker_tlb.sv
module pt_walker_tlb #(
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ENTRIES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [VPN_W-1:0] lookVpn,
  input  logic             flush,
  input  logic             fillEn,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PPN_W-1:0] fillPpn,
  input  logic [2:0]       fillRwx,
  output logic             hit,
  output logic [PPN_W-1:0] hitPpn,
  output logic [2:0]       hitRwx
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] slotValid;
  logic [ENTRIES-1:0] matchVec;
  logic [VPN_W-1:0]   slotVpn [ENTRIES];
  logic [PPN_W-1:0]   slotPpn [ENTRIES];
  logic [2:0]         slotRwx [ENTRIES];
  logic [IDX_W-1:0]   victim;

  for (genvar g = 0; g < ENTRIES; g++) begin : gMatch
    assign matchVec[g] = slotValid[g] && (slotVpn[g] == lookVpn);
  end

  always_comb begin
    hitPpn = '0;
    hitRwx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i]) begin
        hitPpn = hitPpn | slotPpn[i];
        hitRwx = hitRwx | slotRwx[i];
      end
    end
  end

  assign hit = |matchVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid <= '0;
      victim    <= '0;
    end else if (flush) begin
      slotValid <= '0;
    end else if (fillEn) begin
      slotValid[victim] <= 1'b1;
      victim <= (victim == LAST) ? '0 : victim + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fillEn && !flush) begin
      slotVpn[victim] <= fillVpn;
      slotPpn[victim] <= fillPpn;
      slotRwx[victim] <= fillRwx;
    end
  end

endmodule

// File: rtl/pt_walker_dp.sv
module pt_walker_dp
  import pt_walker_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int PAGE_BITS   = 12,
  parameter int TLB_ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [1:0]        reqAccess,
  input  logic              baseWe,
  input  logic [PA_W-1:0]   baseWdata,
  input  logic [PTE_W-1:0]  memRspData,
  output logic              tlbHit,
  output logic [PA_W-1:0]   pteAddr,
  output logic [PA_W-1:0]   rspPaddr,
  output logic [1:0]        rspFault
);
  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PPN_W = PA_W - PAGE_BITS;

  logic [PA_W-1:0]      baseReg;
  logic [VA_W-1:0]      vaReg;
  logic [1:0]           accReg;
  logic                 stale;
  logic [PA_W-1:0]      paddrReg;
  rspCode_e             faultReg;

  logic [VPN_W-1:0]     curVpn;
  logic [PAGE_BITS-1:0] curOff;
  logic                 pteValid;
  logic [2:0]           pteRwx;
  logic [PPN_W-1:0]     ptePpn;
  logic [PPN_W-1:0]     hitPpn;
  logic [2:0]           hitRwx;
  logic                 fillEn;
  logic                 unusedPteBits;

  assign curVpn   = vaReg[VA_W-1:PAGE_BITS];
  assign curOff   = vaReg[PAGE_BITS-1:0];
  assign pteValid = memRspData[PTE_VALID_BIT];
  assign pteRwx   = memRspData[PTE_PERM_LSB +: 3];
  assign ptePpn   = memRspData[PTE_W-1 -: PPN_W];
  assign unusedPteBits = ^memRspData;

  // a base write in this cycle or earlier in the walk blocks the refill
  assign fillEn = strobe.absorb && pteValid && !stale && !baseWe;

  pt_walker_tlb #(
    .VPN_W  (VPN_W),
    .PPN_W  (PPN_W),
    .ENTRIES(TLB_ENTRIES)
  ) u_tlb (
    .clk    (clk),
    .rstN   (rstN),
    .lookVpn(curVpn),
    .flush  (baseWe),
    .fillEn (fillEn),
    .fillVpn(curVpn),
    .fillPpn(ptePpn),
    .fillRwx(pteRwx),
    .hit    (tlbHit),
    .hitPpn (hitPpn),
    .hitRwx (hitRwx)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg  <= '0;
      vaReg    <= '0;
      accReg   <= '0;
      stale    <= 1'b0;
      pteAddr  <= '0;
      paddrReg <= '0;
      faultReg <= RSP_OK;
    end else begin
      if (baseWe) baseReg <= baseWdata;

      if (strobe.accept) begin
        vaReg   <= reqVaddr;
        accReg  <= reqAccess;
        stale   <= baseWe;
        pteAddr <= baseReg + (PA_W'(reqVaddr[VA_W-1:PAGE_BITS]) << 2);
      end else if (baseWe) begin
        stale <= 1'b1;
      end

      if (strobe.lookup && tlbHit) begin
        if (permitted(hitRwx, accReg)) begin
          paddrReg <= {hitPpn, curOff};
          faultReg <= RSP_OK;
        end else begin
          paddrReg <= '0;
          faultReg <= RSP_PROT;
        end
      end else if (strobe.absorb) begin
        if (!pteValid) begin
          paddrReg <= '0;
          faultReg <= RSP_PAGE;
        end else if (permitted(pteRwx, accReg)) begin
          paddrReg <= {ptePpn, curOff};
          faultReg <= RSP_OK;
        end else begin
          paddrReg <= '0;
          faultReg <= RSP_PROT;
        end
      end
    end
  end

  assign rspPaddr = paddrReg;
  assign rspFault = faultReg;

endmodule

// File: rtl/pt_walker_ctrl.sv
module pt_walker_ctrl
  import pt_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        rspReady,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        tlbHit,
  output logic        reqReady,
  output logic        rspValid,
  output logic        memReqValid,
  output walkStrobe_t strobe
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_FETCH, ST_WAIT, ST_RESP
  } walkState_e;

  walkState_e state, nextState;

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:   if (reqValid)    nextState = ST_LOOKUP;
      ST_LOOKUP: nextState = tlbHit ? ST_RESP : ST_FETCH;
      ST_FETCH:  if (memReqReady) nextState = ST_WAIT;
      ST_WAIT:   if (memRspValid) nextState = ST_RESP;
      ST_RESP:   if (rspReady)    nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign reqReady      = (state == ST_IDLE);
  assign rspValid      = (state == ST_RESP);
  assign memReqValid   = (state == ST_FETCH);
  assign strobe.accept = (state == ST_IDLE) && reqValid;
  assign strobe.lookup = (state == ST_LOOKUP);
  assign strobe.absorb = (state == ST_WAIT) && memRspValid;

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int PAGE_BITS   = 12,
  parameter int TLB_ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [1:0]        reqAccess,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [PA_W-1:0]   rspPaddr,
  output logic [1:0]        rspFault,
  input  logic              baseWe,
  input  logic [PA_W-1:0]   baseWdata,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [PA_W-1:0]   memReqAddr,
  input  logic              memRspValid,
  input  logic [PTE_W-1:0]  memRspData
);
  walkStrobe_t strobe;
  logic        tlbHit;

  pt_walker_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .rspReady   (rspReady),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .tlbHit     (tlbHit),
    .reqReady   (reqReady),
    .rspValid   (rspValid),
    .memReqValid(memReqValid),
    .strobe     (strobe)
  );

  pt_walker_dp #(
    .VA_W       (VA_W),
    .PA_W       (PA_W),
    .PAGE_BITS  (PAGE_BITS),
    .TLB_ENTRIES(TLB_ENTRIES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqVaddr  (reqVaddr),
    .reqAccess (reqAccess),
    .baseWe    (baseWe),
    .baseWdata (baseWdata),
    .memRspData(memRspData),
    .tlbHit    (tlbHit),
    .pteAddr   (memReqAddr),
    .rspPaddr  (rspPaddr),
    .rspFault  (rspFault)
  );

endmodule

// File: rtl/pt_walker_checker.sv
module pt_walker_checker #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic [VA_W-1:0] reqVaddr,
  input logic            rspValid,
  input logic            rspReady,
  input logic [PA_W-1:0] rspPaddr,
  input logic [1:0]      rspFault,
  input logic            memReqValid,
  input logic            memReqReady,
  input logic [PA_W-1:0] memReqAddr
);
  logic [PAGE_BITS-1:0] offReg;

  always_ff @(posedge clk) begin
    if (!rstN)                     offReg <= '0;
    else if (reqValid && reqReady) offReg <= reqVaddr[PAGE_BITS-1:0];
  end

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid && $stable(rspPaddr) && $stable(rspFault));

  assert_single_flight_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(reqReady && rspValid));

  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  assert_mem_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady && !rspValid);

  // R4 and R6: faults carry a zero address
  assert_fault_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && (rspFault != 2'd0) |-> rspPaddr == '0);

  assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && (rspFault == 2'd0) |-> rspPaddr[PAGE_BITS-1:0] == offReg);

  assert_code_legal_R6: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> rspFault != 2'd3);

endmodule

bind pt_walker pt_walker_checker #(
  .VA_W     (VA_W),
  .PA_W     (PA_W),
  .PAGE_BITS(PAGE_BITS)
) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .reqVaddr   (reqVaddr),
  .rspValid   (rspValid),
  .rspReady   (rspReady),
  .rspPaddr   (rspPaddr),
  .rspFault   (rspFault),
  .memReqValid(memReqValid),
  .memReqReady(memReqReady),
  .memReqAddr (memReqAddr)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic        reqReady;
  logic [31:0] reqVaddr;
  logic [1:0]  reqAccess;
  logic        rspValid;
  logic        rspReady;
  logic [31:0] rspPaddr;
  logic [1:0]  rspFault;
  logic        baseWe;
  logic [31:0] baseWdata;
  logic        memReqValid;
  logic        memReqReady;
  logic [31:0] memReqAddr;
  logic        memRspValid;
  logic [31:0] memRspData;

  always #5 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr), .reqAccess(reqAccess),
    .rspValid(rspValid), .rspReady(rspReady), .rspPaddr(rspPaddr), .rspFault(rspFault),
    .baseWe(baseWe), .baseWdata(baseWdata),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  typedef struct {
    logic [31:0] paddr;
    logic [1:0]  fault;
    string       tag;
  } exp_t;

  exp_t        expQ[$];
  logic [31:0] ptMem [logic [31:0]];
  int          checks = 0;
  int          fails = 0;
  int          fetchCount = 0;
  logic [31:0] lastMemAddr = '0;
  int          memDelay = 0;
  int          memLat = 1;
  bit          pulseBase = 1'b0;
  logic [31:0] curBase = '0;

  task automatic checkVal(input string tag, input string what,
                          input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] mkPte(input logic [19:0] ppn, input bit v,
                                        input bit r, input bit w, input bit x);
    return {ppn, 8'h00, x, w, r, v};
  endfunction

  // monitor: compares each taken response with the scoreboard head
  always @(negedge clk) begin
    exp_t e;
    if (rstN && rspValid && rspReady) begin
      if (expQ.size() == 0) begin
        checkVal("R9", "unexpected response", 32'd1, 32'd0);
      end else begin
        e = expQ.pop_front();
        checkVal(e.tag, "fault code", {30'd0, rspFault}, {30'd0, e.fault});
        checkVal(e.tag, "physical address", rspPaddr, e.paddr);
      end
    end
  end

  // memory model for table entries
  initial begin
    memReqReady = 1'b0;
    memRspValid = 1'b0;
    memRspData  = '0;
    forever begin
      @(negedge clk);
      if (rstN && memReqValid) begin
        lastMemAddr = memReqAddr;
        fetchCount++;
        repeat (memDelay) @(negedge clk);
        memReqReady = 1'b1;
        @(negedge clk);
        memReqReady = 1'b0;
        repeat (memLat) @(negedge clk);
        memRspData  = ptMem.exists(lastMemAddr) ? ptMem[lastMemAddr] : 32'h0;
        memRspValid = 1'b1;
        if (pulseBase) begin
          baseWe    = 1'b1;
          baseWdata = curBase;
        end
        @(negedge clk);
        memRspValid = 1'b0;
        baseWe      = 1'b0;
      end
    end
  end

  task automatic writeBase(input logic [31:0] b);
    @(negedge clk);
    baseWe    = 1'b1;
    baseWdata = b;
    curBase   = b;
    @(negedge clk);
    baseWe    = 1'b0;
  endtask

  task automatic doReq(input logic [31:0] va, input logic [1:0] acc,
                       input logic [31:0] expPa, input logic [1:0] expF,
                       input int expFetch, input int hold, input string tag);
    exp_t e;
    int   startF;
    e.paddr = expPa;
    e.fault = expF;
    e.tag   = tag;
    expQ.push_back(e);
    startF = fetchCount;
    @(negedge clk);
    reqVaddr  = va;
    reqAccess = acc;
    reqValid  = 1'b1;
    rspReady  = (hold == 0);
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (hold > 0) begin
      while (!rspValid) @(negedge clk);
      repeat (hold) @(negedge clk);
      checkVal("R9", "response held while not taken", {31'd0, rspValid}, 32'd1);
      @(posedge clk);
      #1 rspReady = 1'b1;
    end
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
    checkVal(tag, "memory reads", fetchCount - startF, expFetch);
    if (expFetch == 1)
      checkVal("R2", "entry address", lastMemAddr, curBase + {va[31:12], 2'b00});
  endtask

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL R9 watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN      = 1'b0;
    reqValid  = 1'b0;
    reqVaddr  = '0;
    reqAccess = '0;
    rspReady  = 1'b1;
    baseWe    = 1'b0;
    baseWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkVal("R1", "reqReady", {31'd0, reqReady}, 32'd1);
    checkVal("R1", "rspValid", {31'd0, rspValid}, 32'd0);
    checkVal("R1", "memReqValid", {31'd0, memReqValid}, 32'd0);

    writeBase(32'h0001_0000);
    ptMem[32'h0001_000c] = mkPte(20'h00456, 1, 1, 0, 0);
    doReq(32'h0000_3abc, 2'd0, 32'h0045_6abc, 2'd0, 1, 0, "R1 R3 cold miss");
    doReq(32'h0000_3010, 2'd0, 32'h0045_6010, 2'd0, 0, 0, "R5 hit");
    doReq(32'h0000_3020, 2'd1, 32'h0, 2'd2, 0, 0, "R6 write on hit");

    ptMem[32'h0001_0014] = mkPte(20'h00999, 0, 1, 1, 1);
    doReq(32'h0000_5008, 2'd2, 32'h0, 2'd1, 1, 0, "R4 invalid entry");
    doReq(32'h0000_5008, 2'd2, 32'h0, 2'd1, 1, 0, "R4 not cached");

    ptMem[32'h0001_001c] = mkPte(20'h00abc, 1, 1, 1, 0);
    memDelay = 2;
    memLat   = 4;
    doReq(32'h0000_7ff0, 2'd1, 32'h00ab_cff0, 2'd0, 1, 3, "R10 slow memory");
    memDelay = 0;
    memLat   = 1;
    doReq(32'h0000_7000, 2'd2, 32'h0, 2'd2, 0, 0, "R6 exec on hit");
    doReq(32'h0000_3000, 2'd3, 32'h0, 2'd2, 0, 0, "R6 reserved code");

    ptMem[32'h0001_0024] = mkPte(20'h00321, 1, 0, 0, 1);
    doReq(32'h0000_9444, 2'd0, 32'h0, 2'd2, 1, 0, "R6 read on miss");
    doReq(32'h0000_9444, 2'd2, 32'h0032_1444, 2'd0, 0, 0, "R5 cached after fault");

    writeBase(32'h0001_0000);
    doReq(32'h0000_3abc, 2'd0, 32'h0045_6abc, 2'd0, 1, 0, "R7 flush");
    writeBase(32'h0002_0000);
    ptMem[32'h0002_000c] = mkPte(20'h00777, 1, 1, 0, 0);
    doReq(32'h0000_3abc, 2'd0, 32'h0077_7abc, 2'd0, 1, 0, "R7 new base");

    ptMem[32'h0002_0040] = mkPte(20'h00555, 1, 1, 1, 0);
    pulseBase = 1'b1;
    doReq(32'h0001_0100, 2'd1, 32'h0055_5100, 2'd0, 1, 0, "R8 collide");
    pulseBase = 1'b0;
    doReq(32'h0001_0100, 2'd1, 32'h0055_5100, 2'd0, 1, 0, "R8 refill dropped");
    doReq(32'h0001_0100, 2'd0, 32'h0055_5100, 2'd0, 0, 0, "R5 refill kept");

    writeBase(32'h0002_0000);
    for (int i = 0; i < 5; i++) begin
      ptMem[32'h0002_0000 + (32'(32'h20 + i) << 2)] = mkPte(20'(32'h100 + i), 1, 1, 0, 0);
      doReq(32'(32'h20 + i) << 12, 2'd0, 32'(32'h100 + i) << 12, 2'd0, 1, 0, "R11 fill");
    end
    for (int i = 2; i < 5; i++)
      doReq(32'(32'h20 + i) << 12, 2'd0, 32'(32'h100 + i) << 12, 2'd0, 0, 0, "R11 kept");
    doReq(32'h0002_0000, 2'd0, 32'h0010_0000, 2'd0, 1, 0, "R11 evicted");

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule